// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a slave on a two-wire serial bus. It holds six 8-bit clock-control registers and lets a bus master program them with block writes and fetch them with block reads. The system clock samples SCL and SDA several times per bit. The block detects START and STOP conditions and the clock edges from those samples. It drives SDA only through a pull-down enable, so the pad stays open-drain.

A write sends the write address first. Two bytes follow: a command byte and a count byte. The slave acknowledges both and discards their values. Every later byte lands in the next register, always starting at register 0, because the bus cannot address a single register. A read sends the read address. The slave answers with the register count, then the registers from register 0 upward. When the power-down flag is high, the serial port is shut off but the stored values stay.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, registers 0 to 5 hold 0xF6, 0x3F, 0xE0, 0x7E, 0x00 and 0x00. Register i appears on regs_o bits [8i+7:8i].
- R2: Address byte 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address byte is not acknowledged. The rest of that transfer is then ignored and no register changes.
- R3: In a write, the first two bytes after the address are acknowledged and their values do not reach any register. Each byte after them goes to register 0, 1, 2 and onward in turn. Registers beyond the last byte sent keep their values.
- R4: For every accepted byte, the slave pulls SDA low for the whole ninth SCL pulse. The pull-down enable changes only while SCL is low, except when a transfer is aborted or power-down is raised.
- R5: Write data bytes 7 to 10 are acknowledged and discarded. The 11th data byte gets no acknowledge, and the slave then ignores the bus until the next START or STOP.
- R6: A read returns 0x06 first, then registers 0 to 5, each MSB first. Every byte after those reads as 0x00.
- R7: Reserved bits always read as 0. The writable masks are 0xFE, 0x3F, 0xE0, 0x7F, 0x80 and 0xE3 for registers 0 to 5, and written data is ANDed with the mask.
- R8: When the master does not acknowledge a byte during a read, the slave stops sending. It keeps SDA released until the next START or STOP.
- R9: A START or STOP in the middle of a byte drops the partial byte. Registers written by completed bytes keep their new values, and the next transfer works normally.
- R10: While pwr_down_i is high, the slave releases SDA and ignores the bus. The registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| pwr_down_i | input | 1 | High disables the serial port and holds the registers |
| sda_pull_o | output | 1 | High enables the open-drain pull-down on SDA |
| regs_o | output | 48 | All registers; register i on bits [8i+7:8i] |

## Verification
The bench uses the default parameters: six registers, a ten-byte data limit and a two-stage synchronizer. With these values the overflow edge is easy to reach. A write of eleven data bytes crosses both the register limit and the byte limit, and a read continues past the sixth register into the zero fill. The master model runs SCL at twenty system clocks per bit. This leaves enough margin for the synchronizer delay, so that acknowledge windows, repeated STARTs and mid-byte STOPs can each be tested alone.

// File: rtl/smb_cfg_pkg.sv
// Shared definitions for the serial configuration slave: the state
// encoding, the per-register reset values and the writable-bit masks.
// Assumes register indices beyond the defined six are fully writable
// and reset to zero.
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK_DRV,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT,
        ST_HOLD
    } smb_state_t;

    // Reset value of a register.
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hF6;
            1:       return 8'h3F;
            2:       return 8'hE0;
            3:       return 8'h7E;
            default: return 8'h00;
        endcase
    endfunction

    // Bits of a register that a write may set; the rest read as zero.
    function automatic logic [7:0] reg_mask(input int idx);
        case (idx)
            0:       return 8'hFE;
            1:       return 8'h3F;
            2:       return 8'hE0;
            3:       return 8'h7F;
            4:       return 8'h80;
            5:       return 8'hE3;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL and SDA into the system clock domain and derives the
// clock edges and the START and STOP conditions from them.
// Assumes the system clock samples each SCL level several times.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Shift the raw lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Decode edges and bus conditions from the current and previous samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/smb_cfg_regs.sv
// Bank of configuration registers with masked writes, a read
// multiplexer and a flat copy of all contents. Assumes the slot index
// is already checked against the register count for writes.
module smb_cfg_regs
    import smb_cfg_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int IDX_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_slot,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_slot,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] reg_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] RST_VAL = reg_default(g);
        localparam logic [7:0] WR_MASK = reg_mask(g);

        // Hold one register; load masked data when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                reg_q[g] <= RST_VAL;
            else if (wr_en && (wr_slot == IDX_W'(g)))
                reg_q[g] <= wr_data & WR_MASK;
        end

        assign regs_o[g*8 +: 8] = reg_q[g];
    end

    // Select the register named by the read slot, zero if out of range.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_slot == IDX_W'(i))
                rd_data = reg_q[i];
    end

endmodule

// File: rtl/smb_cfg_slave.sv
// Two-wire slave for block writes and reads of the configuration bank.
// Writes: address, ignored command, ignored count, then data from
// register 0. Reads: address, then count, then registers in order.
// Assumes SCL and SDA are oversampled; no clock stretching.
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int          NUM_REGS    = 6,
    parameter int          MAX_BYTES   = 10,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  WR_ADDR     = 8'hD2,
    parameter logic [7:0]  RD_ADDR     = 8'hD3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  pwr_down_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int               IDX_W     = $clog2(MAX_BYTES + 3) + 1;
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(MAX_BYTES + 2);
    localparam logic [IDX_W-1:0] SLOT_LIM  = IDX_W'(NUM_REGS);
    localparam logic [IDX_W-1:0] IDX_SAT   = '1;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    smb_cfg_pkg::smb_state_t state_q;
    logic [2:0]       bit_cnt_q;
    logic [7:0]       shift_q;
    logic [IDX_W-1:0] idx_q;
    logic             addr_phase_q;
    logic             rd_mode_q;
    logic             pull_q;

    logic [7:0]       rx_byte;
    logic             byte_done;
    logic [IDX_W-1:0] wr_slot;
    logic [IDX_W-1:0] rd_slot;
    logic             wr_en;
    logic [7:0]       rd_data;
    logic [7:0]       tx_src;
    logic [IDX_W-1:0] idx_inc;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_cfg_regs #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (rx_byte),
        .rd_slot (rd_slot),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

    // Decode the completed byte, the write strobe and the next byte to send.
    always_comb begin
        rx_byte   = {shift_q[6:0], sda_s};
        byte_done = (state_q == ST_RX) && scl_rise && (bit_cnt_q == 3'd7);
        wr_slot   = idx_q - IDX_W'(2);
        rd_slot   = idx_q - IDX_W'(1);
        idx_inc   = (idx_q == IDX_SAT) ? idx_q : idx_q + IDX_W'(1);
        wr_en     = byte_done && !addr_phase_q && !rd_mode_q && !pwr_down_i
                    && !start_det && !stop_det
                    && (idx_q >= IDX_W'(2)) && (wr_slot < SLOT_LIM);
        if (idx_q == '0)
            tx_src = 8'(NUM_REGS);
        else if (rd_slot < SLOT_LIM)
            tx_src = rd_data;
        else
            tx_src = 8'h00;
    end

    // Byte-level protocol engine: receive, acknowledge, transmit, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            bit_cnt_q    <= '0;
            shift_q      <= '0;
            idx_q        <= '0;
            addr_phase_q <= 1'b0;
            rd_mode_q    <= 1'b0;
            pull_q       <= 1'b0;
        end else if (pwr_down_i) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
        end else if (start_det) begin
            state_q      <= ST_RX;
            bit_cnt_q    <= '0;
            addr_phase_q <= 1'b1;
            rd_mode_q    <= 1'b0;
            pull_q       <= 1'b0;
        end else if (stop_det) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_RX: begin
                    if (scl_rise) begin
                        shift_q   <= rx_byte;
                        bit_cnt_q <= bit_cnt_q + 3'd1;
                        if (bit_cnt_q == 3'd7) begin
                            if (addr_phase_q) begin
                                addr_phase_q <= 1'b0;
                                idx_q        <= '0;
                                if (rx_byte == WR_ADDR) begin
                                    rd_mode_q <= 1'b0;
                                    state_q   <= ST_ACK_WAIT;
                                end else if (rx_byte == RD_ADDR) begin
                                    rd_mode_q <= 1'b1;
                                    state_q   <= ST_ACK_WAIT;
                                end else begin
                                    state_q <= ST_HOLD;
                                end
                            end else if (idx_q < IDX_LIMIT) begin
                                idx_q   <= idx_inc;
                                state_q <= ST_ACK_WAIT;
                            end else begin
                                state_q <= ST_HOLD;
                            end
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) begin
                        pull_q  <= 1'b1;
                        state_q <= ST_ACK_DRV;
                    end
                end
                ST_ACK_DRV: begin
                    if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (rd_mode_q) begin
                            shift_q <= tx_src;
                            pull_q  <= ~tx_src[7];
                            state_q <= ST_TX;
                        end else begin
                            pull_q  <= 1'b0;
                            state_q <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt_q == 3'd7) begin
                            pull_q  <= 1'b0;
                            state_q <= ST_TX_ACK;
                        end else begin
                            shift_q   <= {shift_q[6:0], 1'b0};
                            pull_q    <= ~shift_q[6];
                            bit_cnt_q <= bit_cnt_q + 3'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            state_q <= ST_HOLD;
                        end else begin
                            idx_q   <= idx_inc;
                            state_q <= ST_TX_NEXT;
                        end
                    end
                end
                ST_TX_NEXT: begin
                    if (scl_fall) begin
                        shift_q   <= tx_src;
                        pull_q    <= ~tx_src[7];
                        bit_cnt_q <= '0;
                        state_q   <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_o = pull_q;

endmodule

// File: rtl/smb_cfg_checks.sv
// Temporal checks on the serial configuration slave, bound to the top.
// Assumes the synchronized SCL and the engine state are visible inside.
module smb_cfg_checks
    import smb_cfg_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pwr_down_i,
    input logic                    sda_pull_o,
    input logic [NUM_REGS*8-1:0]   regs_o,
    input logic                    scl_s,
    input smb_cfg_pkg::smb_state_t state_q
);
    // R10: power-down releases the data line
    a_r10_pd_release: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> !sda_pull_o);

    // R10: power-down keeps register contents
    a_r10_pd_keep: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> $stable(regs_o));

    // R4: the pull-down only starts while SCL is low
    a_r4_pull_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !$past(scl_s));

    // R8: an ignoring slave never drives the line
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !sda_pull_o);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_rsv
        localparam logic [7:0] KEEP = reg_mask(g);
        // R7: reserved bits stay zero
        a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (regs_o[g*8 +: 8] & ~KEEP) == 8'h00);
    end

endmodule

bind smb_cfg_slave smb_cfg_checks #(.NUM_REGS(NUM_REGS)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down_i (pwr_down_i),
    .sda_pull_o (sda_pull_o),
    .regs_o     (regs_o),
    .scl_s      (scl_s),
    .state_q    (state_q)
);

// File: tb/smb_cfg_slave_bench.sv
// Directed bench: a bit-level bus master model, one task per scenario.
module smb_cfg_slave_bench;
    localparam int NR = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_pull = 1'b0;
    logic          pd = 1'b0;
    logic          dut_pull;
    logic [NR*8-1:0] regs;
    logic          sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int edge_viol = 0;
    logic [7:0] exp_r [NR];
    logic [7:0] bytes_b [16];
    logic       acks_b [16];
    logic       addr_ack;
    logic       prev_pull = 1'b0;

    assign sda_line = ~(m_pull | dut_pull);

    always #5 clk = ~clk;

    smb_cfg_slave u_smb_cfg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .pwr_down_i (pd),
        .sda_pull_o (dut_pull),
        .regs_o     (regs)
    );

    // R4 monitor: the slave must not move SDA while SCL is high.
    always @(negedge clk) begin
        if (rst_n && m_scl && (dut_pull !== prev_pull))
            edge_viol++;
        prev_pull = dut_pull;
    end

    function automatic logic [7:0] wmask(input int i);
        case (i)
            0: return 8'hFE;  1: return 8'h3F;  2: return 8'hE0;
            3: return 8'h7F;  4: return 8'h80;  default: return 8'hE3;
        endcase
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NR; i++)
            chk8(req, regs[i*8 +: 8], exp_r[i]);
    endtask

    task automatic bus_start();
        m_pull = 1'b0; wait_n(5);
        m_scl  = 1'b1; wait_n(5);
        m_pull = 1'b1; wait_n(5);
        m_scl  = 1'b0;
    endtask

    task automatic bus_stop();
        m_pull = 1'b1; wait_n(5);
        m_scl  = 1'b1; wait_n(5);
        m_pull = 1'b0; wait_n(10);
    endtask

    task automatic put_bit(input logic b);
        wait_n(5); m_pull = ~b;
        wait_n(5); m_scl = 1'b1;
        wait_n(10); m_scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        wait_n(5); m_pull = 1'b0;
        wait_n(5); m_scl = 1'b1;
        wait_n(5); ack = ~sda_line;
        wait_n(5); m_scl = 1'b0;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        m_pull = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_n(10); m_scl = 1'b1;
            wait_n(5);  b[i] = sda_line;
            wait_n(5);  m_scl = 1'b0;
        end
        wait_n(5); m_pull = give_ack;
        wait_n(5); m_scl = 1'b1;
        wait_n(10); m_scl = 1'b0;
        m_pull = 1'b0;
    endtask

    task automatic write_xfer(input logic [7:0] addr, input int n);
        bus_start();
        put_byte(addr, addr_ack);
        for (int i = 0; i < n; i++) put_byte(bytes_b[i], acks_b[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        exp_r[0] = 8'hF6; exp_r[1] = 8'h3F; exp_r[2] = 8'hE0;
        exp_r[3] = 8'h7E; exp_r[4] = 8'h00; exp_r[5] = 8'h00;
        chk_regs("R1 reset value");
        chk8("R1 line released", {7'd0, dut_pull}, 8'h00);
    endtask

    task automatic t_write_basic();
        bytes_b[0] = 8'h5A; bytes_b[1] = 8'h77;
        for (int i = 0; i < NR; i++) bytes_b[i+2] = 8'hA1 + 8'(i * 8'h11);
        write_xfer(8'hD2, NR + 2);
        chk8("R2 write address ack", {7'd0, addr_ack}, 8'h01);
        for (int i = 0; i < NR + 2; i++) chk8("R4 byte ack", {7'd0, acks_b[i]}, 8'h01);
        for (int i = 0; i < NR; i++) exp_r[i] = bytes_b[i+2] & wmask(i);
        chk_regs("R3 R7 data written in order");
    endtask

    task automatic t_write_partial();
        bytes_b[0] = 8'h3C; bytes_b[1] = 8'h01; bytes_b[2] = 8'h00; bytes_b[3] = 8'hFF;
        write_xfer(8'hD2, 4);
        exp_r[0] = 8'h00; exp_r[1] = 8'h3F;
        chk_regs("R3 short write keeps later registers");
    endtask

    task automatic t_overflow();
        bytes_b[0] = 8'hFF; bytes_b[1] = 8'h0B;
        for (int i = 0; i < 11; i++) bytes_b[i+2] = 8'(i + 1);
        write_xfer(8'hD2, 13);
        for (int i = 0; i < 12; i++) chk8("R5 data up to ten acked", {7'd0, acks_b[i]}, 8'h01);
        chk8("R5 eleventh data byte not acked", {7'd0, acks_b[12]}, 8'h00);
        for (int i = 0; i < NR; i++) exp_r[i] = bytes_b[i+2] & wmask(i);
        chk_regs("R5 extra bytes discarded");
    endtask

    task automatic t_bad_addr();
        bytes_b[0] = 8'h00; bytes_b[1] = 8'h02; bytes_b[2] = 8'hFF; bytes_b[3] = 8'hFF;
        write_xfer(8'hD0, 4);
        chk8("R2 foreign address not acked", {7'd0, addr_ack}, 8'h00);
        chk8("R2 later byte not acked", {7'd0, acks_b[2]}, 8'h00);
        chk_regs("R2 registers untouched");
    endtask

    task automatic t_read();
        logic [7:0] b;
        bus_start();
        put_byte(8'hD3, addr_ack);
        chk8("R2 read address ack", {7'd0, addr_ack}, 8'h01);
        get_byte(1'b1, b);
        chk8("R6 byte count", b, 8'h06);
        for (int i = 0; i < NR; i++) begin
            get_byte(1'b1, b);
            chk8("R6 register readback", b, exp_r[i]);
        end
        get_byte(1'b1, b);
        chk8("R6 zero past last register", b, 8'h00);
        get_byte(1'b0, b);
        chk8("R6 zero past last register", b, 8'h00);
        bus_stop();
    endtask

    task automatic t_nack();
        logic [7:0] b;
        bus_start();
        put_byte(8'hD3, addr_ack);
        get_byte(1'b0, b);
        chk8("R8 count before nack", b, 8'h06);
        get_byte(1'b0, b);
        chk8("R8 line released after nack", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_abort();
        logic [7:0] b;
        logic       a;
        bytes_b[0] = 8'h00; bytes_b[1] = 8'h01; bytes_b[2] = 8'h55;
        bus_start();
        put_byte(8'hD2, a);
        for (int i = 0; i < 3; i++) put_byte(bytes_b[i], a);
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        exp_r[0] = 8'h54;
        chk_regs("R9 stop mid-byte keeps finished bytes");
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h00, a);
        put_byte(8'h01, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(8'hD3, a);
        chk8("R9 address after repeated start", {7'd0, a}, 8'h01);
        get_byte(1'b1, b);
        chk8("R9 count after abort", b, 8'h06);
        get_byte(1'b0, b);
        chk8("R9 register 0 after abort", b, 8'h54);
        bus_stop();
        chk_regs("R9 start mid-byte writes nothing");
    endtask

    task automatic t_power_down();
        pd = 1'b1;
        wait_n(5);
        bytes_b[0] = 8'h00; bytes_b[1] = 8'h01; bytes_b[2] = 8'h00;
        write_xfer(8'hD2, 3);
        chk8("R10 no ack in power-down", {7'd0, addr_ack}, 8'h00);
        chk_regs("R10 registers kept in power-down");
        pd = 1'b0;
        wait_n(5);
        chk_regs("R10 registers kept after power-down");
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        t_reset();
        t_write_basic();
        t_write_partial();
        t_overflow();
        t_bad_addr();
        t_read();
        t_nack();
        t_abort();
        t_power_down();
        n_chk++;
        if (edge_viol != 0) begin
            n_bad++;
            $display("FAIL R4 SDA moved while SCL high: actual %0d expected 0", edge_viol);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule